// File: doc/BRIEF.md
# Event-Driven Status Register Bank

The block gathers typed event notifications from several independent producers and folds them into a bank of sixteen 32-bit status lines. Each event carries a 4-bit type code and a 32-bit value. Counting types add the value to a counter field. "Latest value" types overwrite a 16-bit field. Several lines hold two 16-bit fields side by side. Each time a line takes a new value, the block sends the line address and the full new line on an update stream toward a control-bus register file.

Producers are never stalled. Each source feeds a small FIFO of its own, and that FIFO discards arrivals while it is full. A round-robin merge takes one event per cycle into the status memory. At most one update per line is ever pending, so a line that changes again before its update leaves is reported once, with its newest value.

Top module: `evs_bank`

## Requirements
- R1: Counting codes add to their field. Code 0 adds to line 4 bits 15:0, code 2 to line 4 bits 31:16, code 1 to line 6 bits 15:0 and code 3 to line 6 bits 31:16. On full lines, code 10 adds to line 0, code 11 to line 1, code 12 to line 2, code 8 to line 7 and code 9 to line 8. A 16-bit field adds value[15:0]; a full line adds all 32 bits.
- R2: Latest-value codes write value[15:0] into a half line. Code 4 writes line 3 bits 31:16 and code 5 writes line 3 bits 15:0. Code 6 writes line 5 bits 31:16 and code 7 writes line 5 bits 15:0.
- R3: A 16-bit field wraps modulo 2^16 and leaves the other half of its line untouched. A full-line counter wraps modulo 2^32.
- R4: Each change of a line produces one update carrying the line address (upd_addr) and the whole new line (upd_data). No update is produced in three cases: an event that leaves its line unchanged, any event with code 13 to 15, and any line above 8.
- R5: At most one update per line is pending. Changes that arrive while the output is stalled merge into a single update that carries the latest value. When several lines are pending, the lowest address goes out first.
- R6: While upd_valid is high and upd_ready is low, upd_valid, upd_addr and upd_data hold their values.
- R7: Event inputs have no ready signal. Each source FIFO holds FIFO_DEPTH events and discards an arrival when it is full. A single source sending one event per cycle loses none of them.
- R8: The merge moves at most one event per cycle and takes it only from a non-empty FIFO. It serves the sources in round-robin order, so equally loaded sources get equal shares.
- R9: After reset every line reads zero and no update is pending or presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | NUM_SRC | One event strobe per source |
| ev_code | input | NUM_SRC*4 | Event type code, source i in bits 4i+3:4i |
| ev_value | input | NUM_SRC*32 | Event value, source i in bits 32i+31:32i |
| upd_ready | input | 1 | Consumer accepts the update |
| upd_valid | output | 1 | Update present |
| upd_addr | output | 4 | Address of the changed line |
| upd_data | output | 32 | New value of that line |

## Verification
The assertions make only one assumption about the inputs: upd_ready and the event strobes are known, 0 or 1, once reset is released. Event codes and upd_ready may otherwise change at any cycle. The bench drives every input one time unit after the rising edge and keeps them at known values from time zero. It stalls the consumer across several changes to exercise merging and ordering, and it loads all sources at once to force discards. The stimulus also uses reserved codes and value patterns that leave a line unchanged.

// File: rtl/evs_pkg.sv
package evs_pkg;
  localparam int TYPE_W  = 4;
  localparam int LINE_W  = 32;
  localparam int HALF_W  = 16;
  localparam int LINES   = 16;
  localparam int LINE_AW = 4;

  typedef enum logic [TYPE_W-1:0] {
    EV_MISS_RX = 4'd0, EV_MISS_TX, EV_BADPORT_TX, EV_CONN_FAIL,
    EV_LAST_RX_PORT, EV_LAST_RX_NODE, EV_LAST_TX_PORT, EV_LAST_TX_NODE,
    EV_PKT_RX, EV_PKT_TX, EV_DENIED, EV_GRANTED, EV_MGMT_BYTES
  } ev_kind_e;

  typedef enum logic [1:0] {F_FULL, F_LO, F_HI} field_e;

  typedef struct packed {
    logic               hit;
    logic [LINE_AW-1:0] line;
    field_e             fld;
    logic               replace;
  } ev_route_t;

  localparam logic [LINE_AW-1:0] LN_DENIED  = 4'd0;
  localparam logic [LINE_AW-1:0] LN_GRANTED = 4'd1;
  localparam logic [LINE_AW-1:0] LN_MGMT    = 4'd2;
  localparam logic [LINE_AW-1:0] LN_RX_LAST = 4'd3;
  localparam logic [LINE_AW-1:0] LN_RX_ERR  = 4'd4;
  localparam logic [LINE_AW-1:0] LN_TX_LAST = 4'd5;
  localparam logic [LINE_AW-1:0] LN_TX_ERR  = 4'd6;
  localparam logic [LINE_AW-1:0] LN_PKT_RX  = 4'd7;
  localparam logic [LINE_AW-1:0] LN_PKT_TX  = 4'd8;

  function automatic ev_route_t route_of(input logic [TYPE_W-1:0] code);
    ev_route_t r;
    r.hit = 1'b1; r.line = '0; r.fld = F_FULL; r.replace = 1'b0;
    case (ev_kind_e'(code))
      EV_MISS_RX:      begin r.line = LN_RX_ERR;  r.fld = F_LO; end
      EV_BADPORT_TX:   begin r.line = LN_RX_ERR;  r.fld = F_HI; end
      EV_MISS_TX:      begin r.line = LN_TX_ERR;  r.fld = F_LO; end
      EV_CONN_FAIL:    begin r.line = LN_TX_ERR;  r.fld = F_HI; end
      EV_LAST_RX_PORT: begin r.line = LN_RX_LAST; r.fld = F_HI; r.replace = 1'b1; end
      EV_LAST_RX_NODE: begin r.line = LN_RX_LAST; r.fld = F_LO; r.replace = 1'b1; end
      EV_LAST_TX_PORT: begin r.line = LN_TX_LAST; r.fld = F_HI; r.replace = 1'b1; end
      EV_LAST_TX_NODE: begin r.line = LN_TX_LAST; r.fld = F_LO; r.replace = 1'b1; end
      EV_PKT_RX:       r.line = LN_PKT_RX;
      EV_PKT_TX:       r.line = LN_PKT_TX;
      EV_DENIED:       r.line = LN_DENIED;
      EV_GRANTED:      r.line = LN_GRANTED;
      EV_MGMT_BYTES:   r.line = LN_MGMT;
      default:         r.hit = 1'b0;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/evs_src_fifo.sv
module evs_src_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 36
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         pop,
  output logic         nonempty,
  output logic [W-1:0] head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push;

  // arrivals while full are discarded, never back-pressured
  assign push     = in_valid && (cnt != CW'(DEPTH));
  assign nonempty = (cnt != '0);
  assign head     = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end
endmodule

// File: rtl/evs_rr_merge.sv
module evs_rr_merge #(
  parameter int N = 3,
  parameter int W = 36
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   req,
  input  logic [N*W-1:0] data,
  output logic [N-1:0]   pop,
  output logic           out_valid,
  output logic [W-1:0]   out_data
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;

  logic [PW-1:0] last_q, pick;
  logic          found;

  always_comb begin
    pop   = '0;
    pick  = '0;
    found = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = int'(last_q) + k;
      if (j >= N) j = j - N;
      if (!found && req[j]) begin
        found  = 1'b1;
        pop[j] = 1'b1;
        pick   = PW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      last_q    <= PW'(N - 1);
    end else begin
      out_valid <= found;
      if (found) begin
        out_data <= data[pick*W +: W];
        last_q   <= pick;
      end
    end
  end
endmodule

// File: rtl/evs_status_mem.sv
module evs_status_mem
  import evs_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               ev_valid,
  input  logic [TYPE_W-1:0]  ev_code,
  input  logic [LINE_W-1:0]  ev_val,
  input  logic               upd_ready,
  output logic               upd_valid,
  output logic [LINE_AW-1:0] upd_addr,
  output logic [LINE_W-1:0]  upd_data
);
  logic [LINE_W-1:0]  lines [LINES];
  logic [LINES-1:0]   pend_q, pend_n;
  ev_route_t          rt;
  logic [LINE_W-1:0]  cur, nv;
  logic [HALF_W-1:0]  lo_n, hi_n;
  logic               chg, launch;
  logic [LINE_AW-1:0] sel;

  always_comb begin
    rt   = route_of(ev_code);
    cur  = lines[rt.line];
    lo_n = rt.replace ? ev_val[HALF_W-1:0] : cur[HALF_W-1:0] + ev_val[HALF_W-1:0];
    hi_n = rt.replace ? ev_val[HALF_W-1:0] : cur[LINE_W-1:HALF_W] + ev_val[HALF_W-1:0];
    case (rt.fld)
      F_LO:    nv = {cur[LINE_W-1:HALF_W], lo_n};
      F_HI:    nv = {hi_n, cur[HALF_W-1:0]};
      default: nv = rt.replace ? ev_val : cur + ev_val;
    endcase
    chg = ev_valid && rt.hit && (nv != cur);
  end

  // lowest pending line goes first
  always_comb begin
    sel = '0;
    for (int i = LINES - 1; i >= 0; i--) begin
      if (pend_q[i]) sel = LINE_AW'(i);
    end
  end

  assign launch = (|pend_q) && (!upd_valid || upd_ready);

  always_comb begin
    pend_n = pend_q;
    if (launch) pend_n[sel] = 1'b0;
    if (chg)    pend_n[rt.line] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) lines[i] <= '0;
      pend_q    <= '0;
      upd_valid <= 1'b0;
      upd_addr  <= '0;
      upd_data  <= '0;
    end else begin
      if (chg) lines[rt.line] <= nv;
      pend_q <= pend_n;
      if (launch) begin
        upd_valid <= 1'b1;
        upd_addr  <= sel;
        upd_data  <= lines[sel];
      end else if (upd_ready) begin
        upd_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/evs_bank.sv
module evs_bank
  import evs_pkg::*;
#(
  parameter int NUM_SRC    = 3,
  parameter int FIFO_DEPTH = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        ev_valid,
  input  logic [NUM_SRC*TYPE_W-1:0] ev_code,
  input  logic [NUM_SRC*LINE_W-1:0] ev_value,
  input  logic                      upd_ready,
  output logic                      upd_valid,
  output logic [LINE_AW-1:0]        upd_addr,
  output logic [LINE_W-1:0]         upd_data
);
  localparam int EW = TYPE_W + LINE_W;

  logic [NUM_SRC-1:0]    fifo_nonempty, fifo_pop;
  logic [NUM_SRC*EW-1:0] fifo_head;
  logic                  m_valid;
  logic [EW-1:0]         m_data;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    evs_src_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
      .clk      (clk),
      .rst      (rst),
      .in_valid (ev_valid[s]),
      .in_data  ({ev_code[s*TYPE_W +: TYPE_W], ev_value[s*LINE_W +: LINE_W]}),
      .pop      (fifo_pop[s]),
      .nonempty (fifo_nonempty[s]),
      .head     (fifo_head[s*EW +: EW])
    );
  end

  evs_rr_merge #(.N(NUM_SRC), .W(EW)) u_merge (
    .clk       (clk),
    .rst       (rst),
    .req       (fifo_nonempty),
    .data      (fifo_head),
    .pop       (fifo_pop),
    .out_valid (m_valid),
    .out_data  (m_data)
  );

  evs_status_mem u_mem (
    .clk       (clk),
    .rst       (rst),
    .ev_valid  (m_valid),
    .ev_code   (m_data[EW-1:LINE_W]),
    .ev_val    (m_data[LINE_W-1:0]),
    .upd_ready (upd_ready),
    .upd_valid (upd_valid),
    .upd_addr  (upd_addr),
    .upd_data  (upd_data)
  );
endmodule

// File: rtl/evs_bank_chk.sv
module evs_bank_chk
  import evs_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input logic               clk,
  input logic               rst,
  input logic               upd_valid,
  input logic               upd_ready,
  input logic [LINE_AW-1:0] upd_addr,
  input logic [LINE_W-1:0]  upd_data,
  input logic [NUM_SRC-1:0] src_pop,
  input logic [NUM_SRC-1:0] src_nonempty
);
  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (rst)
    upd_valid && !upd_ready |=> upd_valid && $stable(upd_addr) && $stable(upd_data));

  assert_addr_mapped_R4: assert property (@(posedge clk) disable iff (rst)
    upd_valid |-> upd_addr <= LN_PKT_TX);

  assert_one_pop_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_pop));

  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
    (src_pop & ~src_nonempty) == '0);

  assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !upd_valid);
endmodule

bind evs_bank evs_bank_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .upd_valid    (upd_valid),
  .upd_ready    (upd_ready),
  .upd_addr     (upd_addr),
  .upd_data     (upd_data),
  .src_pop      (fifo_pop),
  .src_nonempty (fifo_nonempty)
);

// File: tb/test_evs_bank.sv
`timescale 1ns/1ps
module test_evs_bank;
  localparam int NS = 3;
  localparam time CLK_P = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NS-1:0] ev_valid = '0;
  logic [NS*4-1:0]  ev_code = '0;
  logic [NS*32-1:0] ev_value = '0;
  logic          upd_ready = 1'b1;
  logic          upd_valid;
  logic [3:0]    upd_addr;
  logic [31:0]   upd_data;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [31:0] shadow [16];
  int          ucount [16];
  logic [3:0]  log_addr [512];
  logic [31:0] log_data [512];
  int          log_n = 0;

  always #(CLK_P/2) clk = ~clk;

  evs_bank #(.NUM_SRC(NS), .FIFO_DEPTH(4)) i_evs_bank (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_value(ev_value), .upd_ready(upd_ready), .upd_valid(upd_valid),
    .upd_addr(upd_addr), .upd_data(upd_data));

  initial begin
    for (int i = 0; i < 16; i++) begin shadow[i] = '0; ucount[i] = 0; end
  end

  // accepted updates are those seen valid&ready between edges
  always @(negedge clk) begin
    if (!rst && upd_valid && upd_ready) begin
      shadow[upd_addr] = upd_data;
      ucount[upd_addr] = ucount[upd_addr] + 1;
      if (log_n < 512) begin
        log_addr[log_n] = upd_addr;
        log_data[log_n] = upd_data;
      end
      log_n = log_n + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic check_range(input string tag, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_ev(input int src, input logic [3:0] code, input logic [31:0] val);
    @(posedge clk); #1;
    ev_valid[src] = 1'b1;
    ev_code[src*4 +: 4] = code;
    ev_value[src*32 +: 32] = val;
    @(posedge clk); #1;
    ev_valid[src] = 1'b0;
  endtask

  task automatic t_reset;
    settle(3);
    check("R9 no update after reset", {31'd0, upd_valid}, 32'd0);
    check("R9 no update logged", log_n, 0);
  endtask

  task automatic t_coalesce_order;
    int base;
    @(posedge clk); #1; upd_ready = 1'b0;
    base = log_n;
    send_ev(0, 4'd10, 32'd1);
    settle(4);
    send_ev(0, 4'd10, 32'd1);
    send_ev(0, 4'd10, 32'd1);
    send_ev(1, 4'd9, 32'd1);
    send_ev(2, 4'd12, 32'd7);
    settle(6);
    check("R6 stalled update held addr", {28'd0, upd_addr}, 32'd0);
    check("R6 stalled update held data", upd_data, 32'd1);
    upd_ready = 1'b1;
    settle(10);
    check("R5 update count", log_n - base, 4);
    check("R5 first addr", {28'd0, log_addr[base]}, 32'd0);
    check("R5 first data", log_data[base], 32'd1);
    check("R5 merged addr", {28'd0, log_addr[base+1]}, 32'd0);
    check("R5 merged data latest", log_data[base+1], 32'd3);
    check("R5 lowest next addr", {28'd0, log_addr[base+2]}, 32'd2);
    check("R1 mgmt bytes line", log_data[base+2], 32'd7);
    check("R5 last addr", {28'd0, log_addr[base+3]}, 32'd8);
    check("R1 packets sent line", log_data[base+3], 32'd1);
  endtask

  task automatic t_pack_wrap;
    int c;
    send_ev(0, 4'd2, 32'd5);
    settle(6);
    check("R1 R9 bad-port half, low half zero", shadow[4], 32'h0005_0000);
    send_ev(1, 4'd0, 32'h0000_FFFF);
    settle(6);
    check("R1 rx miss half", shadow[4], 32'h0005_FFFF);
    send_ev(1, 4'd0, 32'd2);
    settle(6);
    check("R3 16-bit wrap keeps neighbour", shadow[4], 32'h0005_0001);
    c = ucount[4];
    send_ev(2, 4'd0, 32'h0003_0000);
    settle(6);
    check("R4 zero low-half increment no update", ucount[4], c);
    send_ev(0, 4'd9, 32'hFFFF_FFFF);
    settle(6);
    check("R3 32-bit wrap", shadow[8], 32'd0);
    send_ev(0, 4'd9, 32'd3);
    settle(6);
    check("R3 after wrap", shadow[8], 32'd3);
    send_ev(2, 4'd3, 32'h0001_0002);
    settle(6);
    check("R1 conn-fail high half", shadow[6], 32'h0002_0000);
    send_ev(2, 4'd1, 32'd4);
    settle(6);
    check("R1 tx miss low half", shadow[6], 32'h0002_0004);
  endtask

  task automatic t_last_value;
    int c, n;
    send_ev(0, 4'd4, 32'h1234_ABCD);
    settle(6);
    check("R2 rx port high half", shadow[3], 32'hABCD_0000);
    send_ev(1, 4'd5, 32'h0000_0077);
    settle(6);
    check("R2 rx node low half", shadow[3], 32'hABCD_0077);
    c = ucount[3];
    send_ev(2, 4'd4, 32'h0000_ABCD);
    settle(6);
    check("R4 same latest value no update", ucount[3], c);
    send_ev(0, 4'd7, 32'h42);
    settle(6);
    check("R2 tx node", shadow[5], 32'h0000_0042);
    send_ev(0, 4'd6, 32'h9);
    settle(6);
    check("R2 tx port", shadow[5], 32'h0009_0042);
    n = log_n;
    send_ev(1, 4'd13, 32'd5);
    send_ev(1, 4'd15, 32'd5);
    send_ev(2, 4'd11, 32'd0);
    settle(8);
    check("R4 reserved codes and zero add no update", log_n, n);
  endtask

  task automatic t_single_burst;
    @(posedge clk); #1;
    ev_valid[1] = 1'b1; ev_code[7:4] = 4'd8; ev_value[63:32] = 32'd1;
    repeat (20) @(posedge clk);
    #1; ev_valid[1] = 1'b0;
    settle(10);
    check("R7 single source burst no loss", shadow[7], 32'd20);
  endtask

  task automatic t_overload;
    logic [31:0] b0, b1, b2;
    int d0, d1, d2, mx, mn;
    b0 = shadow[2]; b1 = shadow[1]; b2 = shadow[0];
    @(posedge clk); #1;
    ev_valid = '1;
    ev_code = {4'd10, 4'd11, 4'd12};
    ev_value = {32'd1, 32'd1, 32'd1};
    repeat (30) @(posedge clk);
    #1; ev_valid = '0;
    settle(20);
    d0 = int'(shadow[2] - b0); d1 = int'(shadow[1] - b1); d2 = int'(shadow[0] - b2);
    check_range("R7 total under load dropped", d0 + d1 + d2, 30, 89);
    check_range("R8 share src0", d0, 10, 16);
    check_range("R8 share src1", d1, 10, 16);
    check_range("R8 share src2", d2, 10, 16);
    mx = d0; mn = d0;
    if (d1 > mx) mx = d1; if (d1 < mn) mn = d1;
    if (d2 > mx) mx = d2; if (d2 < mn) mn = d2;
    check_range("R8 round-robin balance", mx - mn, 0, 2);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1; rst = 1'b0;
    t_reset();
    t_coalesce_order();
    t_pack_wrap();
    t_last_value();
    t_single_burst();
    t_overload();
    done = 1;
    summary();
    $finish;
  end
endmodule